// File: doc/BRIEF.md
# Streaming Test Pattern Checker

This block sits behind a receive transport layer and checks that the sample words it delivers follow one of three test sequences. The sequences are a seven-bit pseudo-random bit stream, an alternating checkerboard and an incrementing ramp. A two-bit mode input picks the sequence. Each beat carries M converters × S samples × a frame widening factor of N-bit samples. The block never knows the starting value of a sequence. It takes the first accepted beat after reset, or after the mode changes, as its reference. From then on, each accepted beat is compared with the value that the previous data predicts.

A mismatch sets a sticky error flag. The flag stays set until reset or a clear pulse. A second flag records that at least one beat has been accepted, so "no data arrived" and "data arrived and matched" give different outputs. The sink's ready output is always high, so the checker never applies backpressure upstream.

Top module: `pattern_checker`

## Requirements
- R1: `ready_o` is 1 in every cycle, during and after reset.
- R2: In the cycle after reset is released, `err_o` and `got_o` are both 0.
- R3: `got_o` goes to 1 in the cycle after the first beat with `valid_i` high. It stays 1 until reset, and `clr_i` does not clear it.
- R4: A cycle with `valid_i` low never changes `err_o` except through `clr_i`. Its data does not become the reference.
- R5: The first accepted beat after reset, and the first accepted beat after `mode_i` differs from its value in the previous cycle, only seeds the reference. It is never flagged.
- R6: Mode 2 (ramp). Sample k of converter m occupies bits [(m·S·DIV + k)·N +: N], and k = 0 is the earliest sample. Each sample must equal the previous sample of the same converter plus one, modulo 2^N. This holds across beat boundaries and through wrap-around.
- R7: Mode 1 (checkerboard). Each sample must equal the bitwise complement of the previous sample of the same converter, using the layout of R6.
- R8: Mode 0 (PRBS). The word is read as a serial bit stream, with bit 0 earliest and continuing across beats. Each bit must equal the XOR of the bits 7 and 6 positions earlier.
- R9: Mode 3 checks nothing and never sets `err_o`.
- R10: An accepted beat that breaks the selected sequence sets `err_o` in the next cycle. `err_o` then stays 1 until a cycle with `clr_i` high, which makes it 0 in the following cycle.
- R11: If `clr_i` is high in the same cycle as a mismatching beat, `err_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Sequence select: 0 PRBS, 1 checkerboard, 2 ramp, 3 off |
| clr_i | input | 1 | Clears the sticky error flag |
| valid_i | input | 1 | Sink valid |
| data_i | input | M·S·DIV·N | Sink data, samples packed as in R6 |
| ready_o | output | 1 | Sink ready, constant 1 |
| err_o | output | 1 | Sticky mismatch flag |
| got_o | output | 1 | At least one beat accepted since reset |

## Verification
Two situations are hard to reach from the ports. The first is a gap beat whose garbage data must not become the reference. The second is a corrupted beat that carries a clear in the same cycle. In both cases the fault only shows on later beats, or against a flag that is being cleared at that moment. The bench drives a generated ramp, checkerboard or PRBS stream and inserts gap beats with random data between correct beats. It flips a bit in the middle of a beat, away from the bits the next beat's reference depends on, and can assert clear on exactly that beat. A clean stream after the gap shows that no error appeared, and the flag after the combined beat shows that set takes priority over clear.

// File: rtl/pattern_checker.sv
module pattern_checker #(
  parameter int M        = 2,
  parameter int S        = 2,
  parameter int N        = 12,
  parameter int DIV      = 2,
  parameter int PRBS_LEN = 7,
  parameter int PRBS_TAP = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_i,
  input  logic                     clr_i,
  input  logic                     valid_i,
  input  logic [M*S*DIV*N-1:0]     data_i,
  output logic                     ready_o,
  output logic                     err_o,
  output logic                     got_o
);
  localparam int SPB = S * DIV;
  localparam int NS  = M * SPB;
  localparam int W   = NS * N;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [W-1:0] prev_q;
  logic [1:0]   mode_q;
  logic         seeded_q, err_q, got_q;

  logic [NS-1:0] ramp_bad, alt_bad;
  logic [W-1:0]  prbs_bad;
  logic          mismatch, fresh, hit;

  for (genvar cv = 0; cv < M; cv++) begin : g_conv
    for (genvar sv = 0; sv < SPB; sv++) begin : g_samp
      localparam int IDX = cv * SPB + sv;
      logic [N-1:0] cur, prv;
      assign cur = data_i[IDX*N +: N];
      if (sv == 0) begin : g_first
        assign prv = prev_q[(IDX+SPB-1)*N +: N];
      end else begin : g_next
        assign prv = data_i[(IDX-1)*N +: N];
      end
      assign ramp_bad[IDX] = cur != (prv + ONE);
      assign alt_bad[IDX]  = cur != ~prv;
    end
  end

  logic [W+PRBS_LEN-1:0] ext;
  assign ext = {data_i, prev_q[W-1 -: PRBS_LEN]};
  for (genvar j = 0; j < W; j++) begin : g_prbs
    assign prbs_bad[j] = ext[j+PRBS_LEN] ^ ext[j] ^ ext[j+PRBS_LEN-PRBS_TAP];
  end

  always_comb begin
    case (mode_i)
      2'd0:    mismatch = |prbs_bad;
      2'd1:    mismatch = |alt_bad;
      2'd2:    mismatch = |ramp_bad;
      default: mismatch = 1'b0;
    endcase
  end

  assign fresh   = !seeded_q || (mode_i != mode_q);
  assign hit     = valid_i && !fresh && mismatch;
  assign ready_o = 1'b1;
  assign err_o   = err_q;
  assign got_o   = got_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      seeded_q <= 1'b0;
      err_q    <= 1'b0;
      got_q    <= 1'b0;
    end else begin
      mode_q <= mode_i;
      err_q  <= (err_q & ~clr_i) | hit;
      if (valid_i) begin
        seeded_q <= 1'b1;
        got_q    <= 1'b1;
      end else if (mode_i != mode_q) begin
        seeded_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (valid_i) prev_q <= data_i;
  end
endmodule

// File: rtl/pattern_checker_sva.sv
module pattern_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       clr_i,
  input logic       valid_i,
  input logic       ready_o,
  input logic       err_o,
  input logic       got_o
);
  a_r2_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!err_o && !got_o));

  a_r3_got_holds: assert property (@(posedge clk) disable iff (rst)
    got_o |=> got_o);

  a_r3_got_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(got_o) |-> $past(valid_i && ready_o));

  a_r4_idle_err: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !clr_i) |=> $stable(err_o));

  a_r5_first_unchecked: assert property (@(posedge clk) disable iff (rst)
    (!got_o && !err_o && valid_i) |=> !err_o);

  a_r9_mode_off: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd3 && !err_o) |=> !err_o);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> err_o);
endmodule

bind pattern_checker pattern_checker_sva u_sva (
  .clk(clk), .rst(rst), .mode_i(mode_i), .clr_i(clr_i), .valid_i(valid_i),
  .ready_o(ready_o), .err_o(err_o), .got_o(got_o)
);

// File: tb/pattern_checker_bench.sv
module pattern_checker_bench;
  localparam int M = 2, S = 2, N = 12, DIV = 2;
  localparam int SPB = S * DIV;
  localparam int W = M * SPB * N;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, valid = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [W-1:0] data = '0;
  logic ready, err, got;

  always #5 clk = ~clk;

  pattern_checker #(.M(M), .S(S), .N(N), .DIV(DIV)) u_pattern_checker (
    .clk(clk), .rst(rst), .mode_i(mode), .clr_i(clr), .valid_i(valid),
    .data_i(data), .ready_o(ready), .err_o(err), .got_o(got));

  typedef struct { logic e; logic g; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check({it.tag, " err_o"}, err, it.e);
      check({it.tag, " got_o"}, got, it.g);
      check("R1 ready_o", ready, 1'b1);
    end
  end

  logic m_err = 0, m_got = 0, m_seed = 0;
  logic [1:0] m_mode = 0;
  logic [N-1:0] rc [M];
  logic [N-1:0] ac [M];
  logic [6:0] ph = 7'h5A;

  task automatic gen(input int md, output logic [W-1:0] w);
    w = '0;
    if (md == 0) begin
      for (int j = 0; j < W; j++) begin
        logic nb;
        nb = ph[6] ^ ph[5];
        w[j] = nb;
        ph = {ph[5:0], nb};
      end
    end else begin
      for (int m = 0; m < M; m++)
        for (int k = 0; k < SPB; k++) begin
          if (md == 2) begin w[(m*SPB+k)*N +: N] = rc[m]; rc[m] = rc[m] + 1'b1; end
          else begin w[(m*SPB+k)*N +: N] = ac[m]; ac[m] = ~ac[m]; end
        end
    end
  endtask

  task automatic beat(input int md, input logic v, input logic c,
                      input logic [W-1:0] w, input bit bad, input string tag);
    exp_t it;
    logic fresh, hit;
    @(negedge clk);
    mode = md[1:0]; valid = v; clr = c; data = w;
    fresh = !m_seed || (md[1:0] != m_mode);
    hit = v && !fresh && bad && (md != 3);
    m_err = (m_err && !c) || hit;
    if (v) begin m_got = 1; m_seed = 1; end
    else if (md[1:0] != m_mode) m_seed = 0;
    m_mode = md[1:0];
    it.e = m_err; it.g = m_got; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic good(input int md, input string tag);
    logic [W-1:0] w;
    gen(md, w);
    beat(md, 1'b1, 1'b0, w, 1'b0, tag);
  endtask

  task automatic bad_beat(input int md, input logic c, input string tag);
    logic [W-1:0] w;
    gen(md, w);
    w[20] = ~w[20];
    beat(md, 1'b1, c, w, 1'b1, tag);
  endtask

  task automatic idle(input int md, input string tag);
    logic [W-1:0] w;
    for (int i = 0; i < W; i += 32) w[i +: 32] = $urandom;
    beat(md, 1'b0, 1'b0, w, 1'b1, tag);
  endtask

  task automatic clear(input int md, input string tag);
    beat(md, 1'b0, 1'b1, '0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rc[0] = 12'hFFE; rc[1] = 12'hFFA;
    ac[0] = 12'h5A3; ac[1] = 12'h0F0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready_o in reset", ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 err_o after reset", err, 1'b0);
    check("R2 got_o after reset", got, 1'b0);
    idle(2, "R3 no data yet");
    idle(2, "R3 no data yet");
    good(2, "R5 seed beat ramp");
    for (int i = 0; i < 6; i++) good(2, "R6 ramp with wrap");
    idle(2, "R4 gap garbage");
    idle(2, "R4 gap garbage");
    for (int i = 0; i < 3; i++) good(2, "R4 reference kept over gap");
    bad_beat(2, 1'b0, "R6 ramp mismatch");
    for (int i = 0; i < 3; i++) good(2, "R10 sticky");
    idle(2, "R10 sticky idle");
    clear(2, "R10 clear");
    for (int i = 0; i < 3; i++) good(2, "R10 clean after clear");
    bad_beat(2, 1'b1, "R11 clear with mismatch");
    good(2, "R11 still set");
    clear(2, "R3 clear keeps got");
    rc[0] = 12'h123; rc[1] = 12'h800;
    good(1, "R5 seed after mode change");
    for (int i = 0; i < 4; i++) good(1, "R7 checkerboard clean");
    bad_beat(1, 1'b0, "R7 checkerboard mismatch");
    clear(1, "R7 clear");
    good(2, "R5 reseed ramp discontinuity");
    good(2, "R6 ramp after reseed");
    ph = 7'h33;
    good(0, "R5 seed prbs");
    for (int i = 0; i < 12; i++) good(0, "R8 prbs clean");
    idle(0, "R4 prbs gap");
    good(0, "R8 prbs after gap");
    bad_beat(0, 1'b0, "R8 prbs mismatch");
    good(0, "R10 sticky prbs");
    clear(0, "R8 clear");
    for (int i = 0; i < 3; i++) good(0, "R8 prbs clean after clear");
    for (int i = 0; i < 4; i++) bad_beat(3, 1'b0, "R9 mode off");
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule